// File: doc/BRIEF.md
# Multiplexed 4:2:2 Luma/Chroma Output Formatter

This block turns a full-rate stream of signed luma and chroma samples into a 16-bit multiplexed YCbCr bus for a downstream component. Each bus word holds one luma byte and one chroma byte. The chroma byte alternates between the red-difference and blue-difference components from word to word. A new word is loaded on every second clock, so each word stays on the bus for two clock periods. A half-rate strobe marks the first clock of every word, and the next stage can use it as a clock enable.

Before packing, every sample is first clipped to an 8-bit range. Chroma is clipped as a signed value and then moved back to an unsigned value centred on 128. After that, an optional range limit is applied, and its band is chosen by a select input. A bypass input skips the range limit. A line-start pulse restarts the word phase, so the first word of every line carries the red-difference component.

Top module: `ycc_mux_fmt`

## Requirements
- R1: While rst_ni is low, word_o is 0 and strobe_o is 0.
- R2: word_o changes only on the clock edge that makes strobe_o high. On the following clock edge it keeps its value unless line_start_i is high at that edge.
- R3: After the first edge following reset, strobe_o is high for exactly one clock, then low for one clock, and this pattern repeats. The only exception is that line_start_i high at an edge always makes strobe_o high after that edge.
- R4: word_o[15:8] holds the processed luma byte and word_o[7:0] holds the processed chroma byte. Both are taken from the inputs present at the loading edge.
- R5: From one loaded word to the next, the chroma byte alternates between cr_i and cb_i. The first word after reset uses cr_i.
- R6: When line_start_i is high at an edge, a word loads at that edge and uses cr_i, even if that edge falls in the middle of a word. The next word then uses cb_i.
- R7: Luma is read as a signed IN_W-bit value and clipped to 0..255. Negative values give 0, and values above 255 give 255.
- R8: Chroma is read as a signed IN_W-bit value and clipped to -128..127, and then 128 is added. For example, -129 gives 0, -128 gives 0, 0 gives 128, and 127 or more gives 255.
- R9: When bypass_i is 0 and range_sel_i is 0, the clipped luma is limited to 16..235 and the clipped chroma is limited to 16..240.
- R10: When bypass_i is 0 and range_sel_i is 1, both the clipped luma and the clipped chroma are limited to 1..254.
- R11: When bypass_i is 1, range_sel_i has no effect and the clipped values from R7 and R8 go to the bus unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Delayed line-start marker; restarts the word phase |
| range_sel_i | input | 1 | 0: narrow band (luma 16..235, chroma 16..240); 1: wide band 1..254 |
| bypass_i | input | 1 | 1: skip the range limit |
| luma_i | input | IN_W | Signed luma sample |
| cr_i | input | IN_W | Signed red-difference chroma sample |
| cb_i | input | IN_W | Signed blue-difference chroma sample |
| word_o | output | 16 | Multiplexed word {luma, chroma} |
| strobe_o | output | 1 | High during the first clock of each word |

## Verification
A broken phase flag would show up at the ports within one or two clocks. Either the strobe would stay high or low for two clocks in a row, or the bus would change on a clock where it should hold. A wrong chroma-select bit would not change the strobe timing. Instead, the low byte would carry the blue-difference value on the first word after a line start, or it would repeat the same component on two words in a row. Both faults are visible within one word of the next line-start pulse. Range faults show up on the very next loaded word as a byte outside the selected band, or as a clipped value that differs from the band applied to it.

// File: rtl/ycc_fmt_pkg.sv
package ycc_fmt_pkg;
  localparam logic [7:0] NARROW_LO   = 8'd16;
  localparam logic [7:0] LUMA_HI     = 8'd235;
  localparam logic [7:0] CHROMA_HI   = 8'd240;
  localparam logic [7:0] WIDE_LO     = 8'd1;
  localparam logic [7:0] WIDE_HI     = 8'd254;
  localparam int unsigned N_CHROMA   = 2;

  typedef enum logic {CH_CR = 1'b0, CH_CB = 1'b1} chroma_sel_e;
endpackage

// File: rtl/ycc_sample_limit.sv
module ycc_sample_limit
  import ycc_fmt_pkg::*;
#(
  parameter int IN_W      = 10,
  parameter bit IS_CHROMA = 1'b0
) (
  input  logic signed [IN_W-1:0] x_i,
  input  logic                   range_sel_i,
  input  logic                   bypass_i,
  output logic [7:0]             y_o
);
  logic [7:0] clip;
  logic [7:0] lo, hi;

  generate
    if (IS_CHROMA) begin : g_chroma
      localparam logic signed [IN_W-1:0] C_MIN = IN_W'(-128);
      localparam logic signed [IN_W-1:0] C_MAX = IN_W'(127);
      always_comb begin
        if (x_i < C_MIN)      clip = 8'd0;
        else if (x_i > C_MAX) clip = 8'd255;
        else                  clip = x_i[7:0] ^ 8'h80; // +128 in two's complement
      end
    end else begin : g_luma
      localparam logic signed [IN_W-1:0] L_MIN = IN_W'(0);
      localparam logic signed [IN_W-1:0] L_MAX = IN_W'(255);
      always_comb begin
        if (x_i < L_MIN)      clip = 8'd0;
        else if (x_i > L_MAX) clip = 8'd255;
        else                  clip = x_i[7:0];
      end
    end
  endgenerate

  always_comb begin
    lo = range_sel_i ? WIDE_LO : NARROW_LO;
    hi = range_sel_i ? WIDE_HI : (IS_CHROMA ? CHROMA_HI : LUMA_HI);
    if (bypass_i)      y_o = clip;
    else if (clip < lo) y_o = lo;
    else if (clip > hi) y_o = hi;
    else               y_o = clip;
  end
endmodule

// File: rtl/ycc_phase_ctrl.sv
module ycc_phase_ctrl
  import ycc_fmt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        line_start_i,
  output logic        load_o,
  output chroma_sel_e sel_o,
  output logic        strobe_o
);
  logic        hold_q;
  chroma_sel_e next_q;

  assign load_o = line_start_i | ~hold_q;
  assign sel_o  = line_start_i ? CH_CR : next_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= 1'b0;
      next_q   <= CH_CR;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= load_o;
      hold_q   <= load_o;
      if (load_o) next_q <= (sel_o == CH_CR) ? CH_CB : CH_CR;
    end
  end
endmodule

// File: rtl/ycc_mux_fmt.sv
module ycc_mux_fmt
  import ycc_fmt_pkg::*;
#(
  parameter int IN_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            line_start_i,
  input  logic            range_sel_i,
  input  logic            bypass_i,
  input  logic [IN_W-1:0] luma_i,
  input  logic [IN_W-1:0] cr_i,
  input  logic [IN_W-1:0] cb_i,
  output logic [15:0]     word_o,
  output logic            strobe_o
);
  logic [IN_W-1:0] chroma_in [N_CHROMA];
  logic [7:0]      chroma_lim [N_CHROMA];
  logic [7:0]      luma_lim;
  logic            load;
  chroma_sel_e     sel;

  assign chroma_in[CH_CR] = cr_i;
  assign chroma_in[CH_CB] = cb_i;

  ycc_sample_limit #(.IN_W(IN_W), .IS_CHROMA(1'b0)) u_luma (
    .x_i(luma_i), .range_sel_i(range_sel_i), .bypass_i(bypass_i), .y_o(luma_lim)
  );

  for (genvar c = 0; c < N_CHROMA; c++) begin : g_ch
    ycc_sample_limit #(.IN_W(IN_W), .IS_CHROMA(1'b1)) u_lim (
      .x_i(chroma_in[c]), .range_sel_i(range_sel_i), .bypass_i(bypass_i),
      .y_o(chroma_lim[c])
    );
  end

  ycc_phase_ctrl u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i),
    .load_o(load), .sel_o(sel), .strobe_o(strobe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_o <= '0;
    else if (load) word_o <= {luma_lim, chroma_lim[sel]};
  end
endmodule

// File: rtl/ycc_mux_fmt_chk.sv
module ycc_mux_fmt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        line_start_i,
  input logic        range_sel_i,
  input logic        bypass_i,
  input logic [15:0] word_o,
  input logic        strobe_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> (word_o == 16'd0 && !strobe_o));

  // R2
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> $stable(word_o));

  // R3
  strobe_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o && !line_start_i |=> !strobe_o);

  // R3
  strobe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |=> strobe_o);

  // R6
  line_resync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> strobe_o);

  // R9
  narrow_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && !$past(bypass_i) && !$past(range_sel_i)) |->
      (word_o[15:8] >= 8'd16 && word_o[15:8] <= 8'd235 &&
       word_o[7:0]  >= 8'd16 && word_o[7:0]  <= 8'd240));

  // R10
  wide_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && !$past(bypass_i) && $past(range_sel_i)) |->
      (word_o[15:8] >= 8'd1 && word_o[15:8] <= 8'd254 &&
       word_o[7:0]  >= 8'd1 && word_o[7:0]  <= 8'd254));
endmodule

bind ycc_mux_fmt ycc_mux_fmt_chk u_chk (.*);

// File: tb/tb_ycc_mux_fmt.sv
module tb_ycc_mux_fmt;
  localparam int IN_W = 10;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            line_start_i = 1'b0;
  logic            range_sel_i = 1'b0;
  logic            bypass_i = 1'b0;
  logic [IN_W-1:0] luma_i = '0;
  logic [IN_W-1:0] cr_i = '0;
  logic [IN_W-1:0] cb_i = '0;
  logic [15:0]     word_o;
  logic            strobe_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] m_word;
  bit m_strobe, m_hold, m_cb;

  always #5 clk_i = ~clk_i;

  ycc_mux_fmt #(.IN_W(IN_W)) dut (.*);

  function automatic int sval(logic [IN_W-1:0] v);
    return int'(signed'(v));
  endfunction

  function automatic logic [7:0] ref_luma(logic [IN_W-1:0] v, bit sel, bit byp);
    int c = sval(v);
    int lo, hi;
    if (c < 0) c = 0;
    if (c > 255) c = 255;
    lo = sel ? 1 : 16;
    hi = sel ? 254 : 235;
    if (!byp) begin
      if (c < lo) c = lo;
      if (c > hi) c = hi;
    end
    return 8'(c);
  endfunction

  function automatic logic [7:0] ref_chroma(logic [IN_W-1:0] v, bit sel, bit byp);
    int c = sval(v);
    int lo, hi;
    if (c < -128) c = -128;
    if (c > 127) c = 127;
    c = c + 128;
    lo = sel ? 1 : 16;
    hi = sel ? 254 : 240;
    if (!byp) begin
      if (c < lo) c = lo;
      if (c > hi) c = hi;
    end
    return 8'(c);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // apply one vector at a negedge, advance one clock, compare at the next negedge
  task automatic apply(bit ls, bit sel, bit byp, logic [IN_W-1:0] l,
                       logic [IN_W-1:0] r, logic [IN_W-1:0] b);
    string tag;
    line_start_i = ls; range_sel_i = sel; bypass_i = byp;
    luma_i = l; cr_i = r; cb_i = b;
    tag = byp ? "R4 R7 R8 R11" : (sel ? "R4 R10" : "R4 R9");
    if (ls) begin // R6: resync loads Cr
      m_word = {ref_luma(l, sel, byp), ref_chroma(r, sel, byp)};
      m_strobe = 1; m_hold = 1; m_cb = 1;
      tag = {tag, " R6"};
    end else if (!m_hold) begin
      m_word = {ref_luma(l, sel, byp), m_cb ? ref_chroma(b, sel, byp) : ref_chroma(r, sel, byp)};
      m_strobe = 1; m_hold = 1; m_cb = ~m_cb;
      tag = {tag, " R5"};
    end else begin
      m_strobe = 0; m_hold = 0;
      tag = "R2";
    end
    @(negedge clk_i);
    check(tag, word_o, m_word);
    check("R3 strobe", {15'd0, strobe_o}, {15'd0, m_strobe});
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    m_word = '0; m_strobe = 0; m_hold = 0; m_cb = 0;
    repeat (3) @(negedge clk_i);
    // R1
    check("R1 word", word_o, 16'd0);
    check("R1 strobe", {15'd0, strobe_o}, 16'd0);
    rst_ni = 1'b1;

    // R5: first word after reset uses Cr, then Cb
    apply(0, 0, 1, 10'sd100, 10'sd5, -10'sd7);
    apply(0, 0, 1, 10'sd1, 10'sd1, 10'sd1);
    apply(0, 0, 1, 10'sd200, 10'sd5, -10'sd7);
    apply(0, 0, 1, 10'sd2, 10'sd2, 10'sd2);
    // R7 R8 clip corners under bypass
    apply(0, 0, 1, -10'sd512, -10'sd129, -10'sd128);
    apply(0, 0, 1, 10'sd0, 10'sd0, 10'sd0);
    apply(0, 0, 1, 10'sd511, 10'sd127, 10'sd128);
    apply(0, 0, 1, 10'sd0, 10'sd0, 10'sd0);
    apply(0, 0, 1, 10'sd256, 10'sd0, -10'sd1);
    apply(0, 0, 1, 10'sd0, 10'sd0, 10'sd0);
    apply(0, 0, 1, 10'sd255, -10'sd1, 10'sd511);
    // R9 R10 band edges
    apply(0, 0, 0, 10'sd0, -10'sd128, 10'sd127);
    apply(0, 0, 0, 10'sd0, 10'sd0, 10'sd0);
    apply(0, 0, 0, 10'sd255, 10'sd127, -10'sd128);
    apply(0, 1, 0, 10'sd0, -10'sd128, 10'sd127);
    apply(0, 1, 0, 10'sd255, 10'sd0, 10'sd0);
    apply(0, 1, 0, 10'sd255, 10'sd127, -10'sd128);
    // R6: line start mid-word, then back-to-back
    apply(0, 0, 0, 10'sd50, 10'sd10, 10'sd20);
    apply(1, 0, 0, 10'sd60, 10'sd30, 10'sd40);
    apply(1, 1, 0, 10'sd70, -10'sd30, -10'sd40);
    apply(0, 1, 0, 10'sd80, -10'sd50, -10'sd60);
    apply(0, 1, 0, 10'sd90, -10'sd70, -10'sd80);

    for (int i = 0; i < 4000; i++) begin
      bit ls = ($urandom_range(0, 15) == 0);
      bit sel = $urandom_range(0, 1);
      bit byp = ($urandom_range(0, 3) == 0);
      apply(ls, sel, byp, IN_W'($urandom), IN_W'($urandom), IN_W'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule